// File: doc/BRIEF.md
# Processor Signature Patch Selector

This block walks through a stream of patch headers, one header beat per patch, each optionally followed by a run of extended signature beats. It finds the patch that fits the running processor and has the best revision. A scan starts with a start pulse. The pulse loads the processor signature, the three-bit platform field, the current revision, the selection mode and the stream length in bytes. For every header the block decides whether the processor matches. It first tests the header's own signature and flag mask. If that misses and the header has room for an extended table, it tests each extended entry as it arrives. A match is kept according to the mode: newer mode looks for an upgrade, exact mode looks for the patch already loaded. An end pulse closes the scan, and the result stays on the outputs until the next start.

Checksum checking is done upstream. Its verdict arrives with each header as a valid flag. Any structural fault ends the scan at once with the error output set and no selection. The faults are an invalid header, a zero or oversized patch, too many extended entries, a stream that ends mid-patch, or bytes left over at the end.

Top module: `psel_patch_selector`

## Requirements
- R1: When `pf_known` is 1 the processor flag mask is 1 shifted left by `plat_field`, an 8-bit one-hot value. When `pf_known` is 0 the mask is zero.
- R2: A header or extended entry matches when its signature equals the processor signature and either both flag masks are zero or their bitwise AND is non-zero.
- R3: A header has extended entries only when its effective total size exceeds its effective data size plus `HDR_BYTES` (48). In that case exactly `hdr_ext_count` extended beats follow, and any matching entry makes the patch match. Otherwise the count field is ignored and the next beat is a header.
- R4: In newer mode (`exact_mode`=0) the best revision starts at the current revision. A matching patch is selected only if its revision is strictly greater, as an unsigned number, than the best so far. On a tie the earlier patch stays selected.
- R5: In exact mode (`exact_mode`=1) a matching patch is selected only if its revision equals the current revision. Among several such patches the last one in the stream wins.
- R6: A header with `hdr_ok`=0, an effective total size of zero, or an effective total size larger than the remaining stream bytes ends the scan at the clock edge where it is accepted. That edge sets `done`=1 and `err`=1 and clears `found`.
- R7: A header with `hdr_data_size`=0 ignores `hdr_total_size`. It uses a total of `DEF_TOTAL` (2048) bytes and a data size of `DEF_TOTAL`-`HDR_BYTES`, so it has no extended entries.
- R8: A header with extended entries whose count exceeds `MAX_EXT` (15) aborts the scan as in R6. A count of exactly `MAX_EXT` is accepted.
- R9: `scan_end` finishes the scan with `done`=1. If stream bytes remain, `err`=1 and `found`=0. It may arrive in the same cycle as a patch's last beat, and that patch is still judged. An end pulse before a patch's extended entries are complete is an error.
- R10: Headers are numbered from 0 in stream order. `sel_idx` and `sel_rev` give the number and revision of the selected patch. All outputs update on the clock edge that accepts the deciding beat.
- R11: Reset clears `done`, `found`, `err`, `sel_idx` and `sel_rev`. `scan_start` restarts the scan from any state and discards the previous one. After `done`, the outputs hold until the next start, and beats arriving in the meantime have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_start | input | 1 | Start a new scan, loading the context inputs |
| scan_len | input | SIZE_W | Stream length in bytes |
| cpu_sig | input | SIG_W | Processor signature |
| plat_field | input | 3 | Platform field selecting the processor flag bit |
| pf_known | input | 1 | Processor flag mask valid; 0 gives a zero mask |
| cur_rev | input | REV_W | Revision currently loaded |
| exact_mode | input | 1 | 0 selects newer revisions, 1 selects the current revision |
| hdr_valid | input | 1 | Header beat present |
| hdr_ok | input | 1 | Upstream validity verdict for this patch |
| hdr_sig | input | SIG_W | Header signature |
| hdr_pf | input | 8 | Header flag mask |
| hdr_rev | input | REV_W | Header revision |
| hdr_data_size | input | SIZE_W | Data size field |
| hdr_total_size | input | SIZE_W | Total size field |
| hdr_ext_count | input | CNT_W | Extended entry count |
| ext_valid | input | 1 | Extended entry beat present |
| ext_sig | input | SIG_W | Extended entry signature |
| ext_pf | input | 8 | Extended entry flag mask |
| scan_end | input | 1 | Stream ends after this cycle's beat |
| done | output | 1 | Scan finished |
| found | output | 1 | A patch is selected |
| err | output | 1 | Scan aborted or ended inconsistently |
| sel_idx | output | IDX_W | Index of the selected patch |
| sel_rev | output | REV_W | Revision of the selected patch (current revision before any selection) |

## Verification
The end of the stream can coincide with the beat that decides a patch. That beat is either a header with no extended table or the last extended entry of a patch. The bench raises `scan_end` together with such beats and expects the final result to include that patch. It also raises `scan_end` on a non-final extended beat and expects an error instead. A behavioural model in the bench follows the same stimulus and is compared with every output on every clock. Hand-computed expectations are checked at the end of each scan.

// File: rtl/psel_pkg.sv
package psel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_EXT  = 2'd2,
    ST_FIN  = 2'd3
  } psel_state_e;

  // width of the platform field that selects the processor flag bit
  localparam int PF_FIELD_W = 3;
endpackage

// File: rtl/psel_rst_sync.sv
module psel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/psel_sig_match.sv
module psel_sig_match #(
  parameter int SIG_W = 32,
  parameter int PF_W  = 8
) (
  input  logic [SIG_W-1:0] proc_sig,
  input  logic [PF_W-1:0]  proc_pf,
  input  logic [SIG_W-1:0] cand_sig,
  input  logic [PF_W-1:0]  cand_pf,
  output logic             hit
);
  logic both_zero;
  logic overlap;

  assign both_zero = (proc_pf == '0) && (cand_pf == '0);
  assign overlap   = (proc_pf & cand_pf) != '0;
  assign hit       = (proc_sig == cand_sig) && (both_zero || overlap);
endmodule

// File: rtl/psel_size_check.sv
module psel_size_check #(
  parameter int SIZE_W    = 32,
  parameter int CNT_W     = 8,
  parameter int HDR_BYTES = 48,
  parameter int DEF_TOTAL = 2048,
  parameter int MAX_EXT   = 15
) (
  input  logic              hdr_ok,
  input  logic [SIZE_W-1:0] data_size,
  input  logic [SIZE_W-1:0] total_size,
  input  logic [CNT_W-1:0]  ext_count,
  input  logic [SIZE_W-1:0] remaining,
  output logic              has_ext,
  output logic              bad,
  output logic [SIZE_W-1:0] rem_next
);
  localparam int DEF_DATA = DEF_TOTAL - HDR_BYTES;

  logic [SIZE_W-1:0] total_eff;
  logic [SIZE_W-1:0] data_eff;
  logic [SIZE_W:0]   body_end;
  logic              cnt_over;

  assign total_eff = (data_size == '0) ? SIZE_W'(DEF_TOTAL) : total_size;
  assign data_eff  = (data_size == '0) ? SIZE_W'(DEF_DATA)  : data_size;
  assign body_end  = {1'b0, data_eff} + (SIZE_W+1)'(HDR_BYTES);
  assign has_ext   = {1'b0, total_eff} > body_end;
  assign cnt_over  = has_ext && (int'(ext_count) > MAX_EXT);
  assign bad       = !hdr_ok || (total_eff == '0) || (total_eff > remaining) || cnt_over;
  assign rem_next  = remaining - total_eff;
endmodule

// File: rtl/psel_rev_policy.sv
module psel_rev_policy #(
  parameter int REV_W = 32
) (
  input  logic             exact,
  input  logic             hit,
  input  logic [REV_W-1:0] cand_rev,
  input  logic [REV_W-1:0] best_rev,
  input  logic [REV_W-1:0] cur_rev,
  output logic             keep
);
  logic better;

  assign better = exact ? (cand_rev == cur_rev) : (cand_rev > best_rev);
  assign keep   = hit && better;
endmodule

// File: rtl/psel_patch_selector.sv
module psel_patch_selector
  import psel_pkg::*;
#(
  parameter int SIG_W     = 32,
  parameter int REV_W     = 32,
  parameter int SIZE_W    = 32,
  parameter int CNT_W     = 8,
  parameter int IDX_W     = 8,
  parameter int HDR_BYTES = 48,
  parameter int DEF_TOTAL = 2048,
  parameter int MAX_EXT   = 15,
  localparam int PF_W     = 1 << PF_FIELD_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scan_start,
  input  logic [SIZE_W-1:0]     scan_len,
  input  logic [SIG_W-1:0]      cpu_sig,
  input  logic [PF_FIELD_W-1:0] plat_field,
  input  logic                  pf_known,
  input  logic [REV_W-1:0]      cur_rev,
  input  logic                  exact_mode,
  input  logic                  hdr_valid,
  input  logic                  hdr_ok,
  input  logic [SIG_W-1:0]      hdr_sig,
  input  logic [PF_W-1:0]       hdr_pf,
  input  logic [REV_W-1:0]      hdr_rev,
  input  logic [SIZE_W-1:0]     hdr_data_size,
  input  logic [SIZE_W-1:0]     hdr_total_size,
  input  logic [CNT_W-1:0]      hdr_ext_count,
  input  logic                  ext_valid,
  input  logic [SIG_W-1:0]      ext_sig,
  input  logic [PF_W-1:0]       ext_pf,
  input  logic                  scan_end,
  output logic                  done,
  output logic                  found,
  output logic                  err,
  output logic [IDX_W-1:0]      sel_idx,
  output logic [REV_W-1:0]      sel_rev
);
  logic srst_n;

  psel_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // scan context, loaded on start only
  logic [SIG_W-1:0] cpu_sig_q;
  logic [PF_W-1:0]  cpu_pf_q;
  logic [REV_W-1:0] cur_q;
  logic             mode_q;
  logic [PF_W-1:0]  cpu_pf_new;

  assign cpu_pf_new = pf_known ? (PF_W'(1) << plat_field) : '0;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cpu_sig_q <= '0;
      cpu_pf_q  <= '0;
      cur_q     <= '0;
      mode_q    <= 1'b0;
    end else if (scan_start) begin
      cpu_sig_q <= cpu_sig;
      cpu_pf_q  <= cpu_pf_new;
      cur_q     <= cur_rev;
      mode_q    <= exact_mode;
    end
  end

  // scan state
  psel_state_e       state_q, state_d;
  logic [SIZE_W-1:0] rem_q, rem_d;
  logic [REV_W-1:0]  best_q, best_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              found_q, found_d;
  logic              err_q, err_d;
  logic              done_q, done_d;
  logic [IDX_W-1:0]  hcnt_q, hcnt_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              hitacc_q, hitacc_d;
  logic [REV_W-1:0]  cand_rev_q, cand_rev_d;
  logic [IDX_W-1:0]  cand_idx_q, cand_idx_d;

  // per-beat evaluation
  logic              main_hit;
  logic              ext_hit;
  logic              sz_has_ext;
  logic              sz_bad;
  logic [SIZE_W-1:0] sz_rem_next;
  logic              pol_hit;
  logic [REV_W-1:0]  pol_rev;
  logic              pol_keep;
  logic              in_ext;

  psel_sig_match #(.SIG_W(SIG_W), .PF_W(PF_W)) u_main_match (
    .proc_sig (cpu_sig_q),
    .proc_pf  (cpu_pf_q),
    .cand_sig (hdr_sig),
    .cand_pf  (hdr_pf),
    .hit      (main_hit)
  );

  psel_sig_match #(.SIG_W(SIG_W), .PF_W(PF_W)) u_ext_match (
    .proc_sig (cpu_sig_q),
    .proc_pf  (cpu_pf_q),
    .cand_sig (ext_sig),
    .cand_pf  (ext_pf),
    .hit      (ext_hit)
  );

  psel_size_check #(
    .SIZE_W    (SIZE_W),
    .CNT_W     (CNT_W),
    .HDR_BYTES (HDR_BYTES),
    .DEF_TOTAL (DEF_TOTAL),
    .MAX_EXT   (MAX_EXT)
  ) u_size (
    .hdr_ok     (hdr_ok),
    .data_size  (hdr_data_size),
    .total_size (hdr_total_size),
    .ext_count  (hdr_ext_count),
    .remaining  (rem_q),
    .has_ext    (sz_has_ext),
    .bad        (sz_bad),
    .rem_next   (sz_rem_next)
  );

  assign in_ext  = (state_q == ST_EXT);
  assign pol_hit = in_ext ? (hitacc_q | ext_hit) : main_hit;
  assign pol_rev = in_ext ? cand_rev_q : hdr_rev;

  psel_rev_policy #(.REV_W(REV_W)) u_policy (
    .exact    (mode_q),
    .hit      (pol_hit),
    .cand_rev (pol_rev),
    .best_rev (best_q),
    .cur_rev  (cur_q),
    .keep     (pol_keep)
  );

  logic fin_req;
  logic abort_req;

  always_comb begin
    state_d    = state_q;
    rem_d      = rem_q;
    best_d     = best_q;
    idx_d      = idx_q;
    found_d    = found_q;
    err_d      = err_q;
    done_d     = done_q;
    hcnt_d     = hcnt_q;
    left_d     = left_q;
    hitacc_d   = hitacc_q;
    cand_rev_d = cand_rev_q;
    cand_idx_d = cand_idx_q;
    fin_req    = 1'b0;
    abort_req  = 1'b0;

    if (scan_start) begin
      state_d  = ST_SCAN;
      rem_d    = scan_len;
      best_d   = cur_rev;
      idx_d    = '0;
      found_d  = 1'b0;
      err_d    = 1'b0;
      done_d   = 1'b0;
      hcnt_d   = '0;
      left_d   = '0;
      hitacc_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_SCAN: begin
          fin_req = scan_end;
          if (hdr_valid) begin
            if (sz_bad) begin
              abort_req = 1'b1;
              fin_req   = 1'b0;
            end else begin
              rem_d      = sz_rem_next;
              hcnt_d     = hcnt_q + IDX_W'(1);
              cand_idx_d = hcnt_q;
              cand_rev_d = hdr_rev;
              if (sz_has_ext && (hdr_ext_count != '0)) begin
                state_d   = ST_EXT;
                left_d    = hdr_ext_count;
                hitacc_d  = main_hit;
                abort_req = scan_end;
                fin_req   = 1'b0;
              end else if (pol_keep) begin
                best_d  = hdr_rev;
                idx_d   = hcnt_q;
                found_d = 1'b1;
              end
            end
          end
        end
        ST_EXT: begin
          if (ext_valid) begin
            hitacc_d = hitacc_q | ext_hit;
            left_d   = left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) begin
              state_d = ST_SCAN;
              fin_req = scan_end;
              if (pol_keep) begin
                best_d  = cand_rev_q;
                idx_d   = cand_idx_q;
                found_d = 1'b1;
              end
            end else begin
              abort_req = scan_end;
            end
          end else begin
            abort_req = scan_end;
          end
        end
        default: ;
      endcase

      if (abort_req) begin
        state_d = ST_FIN;
        done_d  = 1'b1;
        err_d   = 1'b1;
        found_d = 1'b0;
      end else if (fin_req) begin
        state_d = ST_FIN;
        done_d  = 1'b1;
        if (rem_d != '0) begin
          err_d   = 1'b1;
          found_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q    <= ST_IDLE;
      rem_q      <= '0;
      best_q     <= '0;
      idx_q      <= '0;
      found_q    <= 1'b0;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
      hcnt_q     <= '0;
      left_q     <= '0;
      hitacc_q   <= 1'b0;
      cand_rev_q <= '0;
      cand_idx_q <= '0;
    end else begin
      state_q    <= state_d;
      rem_q      <= rem_d;
      best_q     <= best_d;
      idx_q      <= idx_d;
      found_q    <= found_d;
      err_q      <= err_d;
      done_q     <= done_d;
      hcnt_q     <= hcnt_d;
      left_q     <= left_d;
      hitacc_q   <= hitacc_d;
      cand_rev_q <= cand_rev_d;
      cand_idx_q <= cand_idx_d;
    end
  end

  assign done    = done_q;
  assign found   = found_q;
  assign err     = err_q;
  assign sel_idx = idx_q;
  assign sel_rev = best_q;
endmodule

// File: rtl/psel_checker.sv
module psel_checker #(
  parameter int REV_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scan_start,
  input logic             hdr_valid,
  input logic             ext_valid,
  input logic             scan_end,
  input logic             done,
  input logic             found,
  input logic             err,
  input logic [REV_W-1:0] sel_rev,
  input logic [REV_W-1:0] cur_q,
  input logic             mode_q
);
  // R6: an aborted scan never reports a selection
  a_r6_err_no_found: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !found);

  // R11: completion holds until a new start
  a_r11_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done && !scan_start |=> done);

  // R11: error holds until a new start
  a_r11_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    err && !scan_start |=> err);

  // R4: the selected revision never falls within a scan
  a_r4_rev_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    found && !scan_start |=> sel_rev >= $past(sel_rev));

  // R5: exact mode only ever selects the current revision
  a_r5_exact_equal: assert property (@(posedge clk) disable iff (!rst_n)
    found && mode_q |-> sel_rev == cur_q);

  // R10: a selection appears only on a header or extended beat
  a_r10_found_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(found) |-> $past(hdr_valid || ext_valid));

  // R9: completion follows an end pulse or a header abort
  a_r9_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(scan_end || hdr_valid));
endmodule

bind psel_patch_selector psel_checker #(.REV_W(REV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scan_start (scan_start),
  .hdr_valid  (hdr_valid),
  .ext_valid  (ext_valid),
  .scan_end   (scan_end),
  .done       (done),
  .found      (found),
  .err        (err),
  .sel_rev    (sel_rev),
  .cur_q      (cur_q),
  .mode_q     (mode_q)
);

// File: tb/tb_psel_patch_selector.sv
module tb_psel_patch_selector;
  localparam logic [31:0] SIG  = 32'h000A_0655;
  localparam logic [31:0] BAD  = 32'h000B_0001;
  localparam logic [31:0] PLEN = 32'd1048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_start = 1'b0;
  logic [31:0] scan_len = '0;
  logic [31:0] cpu_sig = SIG;
  logic [2:0]  plat_field = '0;
  logic        pf_known = 1'b0;
  logic [31:0] cur_rev = '0;
  logic        exact_mode = 1'b0;
  logic        hdr_valid = 1'b0;
  logic        hdr_ok = 1'b0;
  logic [31:0] hdr_sig = '0;
  logic [7:0]  hdr_pf = '0;
  logic [31:0] hdr_rev = '0;
  logic [31:0] hdr_data_size = '0;
  logic [31:0] hdr_total_size = '0;
  logic [7:0]  hdr_ext_count = '0;
  logic        ext_valid = 1'b0;
  logic [31:0] ext_sig = '0;
  logic [7:0]  ext_pf = '0;
  logic        scan_end = 1'b0;
  logic        done, found, err;
  logic [7:0]  sel_idx;
  logic [31:0] sel_rev;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  string tag = "R11";

  always #10 clk = ~clk;

  psel_patch_selector dut (
    .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .scan_len(scan_len),
    .cpu_sig(cpu_sig), .plat_field(plat_field), .pf_known(pf_known),
    .cur_rev(cur_rev), .exact_mode(exact_mode), .hdr_valid(hdr_valid),
    .hdr_ok(hdr_ok), .hdr_sig(hdr_sig), .hdr_pf(hdr_pf), .hdr_rev(hdr_rev),
    .hdr_data_size(hdr_data_size), .hdr_total_size(hdr_total_size),
    .hdr_ext_count(hdr_ext_count), .ext_valid(ext_valid), .ext_sig(ext_sig),
    .ext_pf(ext_pf), .scan_end(scan_end), .done(done), .found(found),
    .err(err), .sel_idx(sel_idx), .sel_rev(sel_rev)
  );

  // ---------------- behavioural reference model ----------------
  int          m_st;
  logic        m_done, m_found, m_err;
  logic [7:0]  m_idx;
  logic [31:0] m_rev;
  logic [31:0] m_rem, m_cur, m_sig, m_crev;
  logic [7:0]  m_pf, m_hc, m_cidx;
  int          m_left;
  bit          m_mode, m_hit;

  function automatic bit m_match(input logic [31:0] s, input logic [7:0] p);
    return (s == m_sig) && (((p == 8'h00) && (m_pf == 8'h00)) || ((p & m_pf) != 8'h00));
  endfunction

  task automatic m_fail();
    m_st = 3; m_done = 1; m_err = 1; m_found = 0;
  endtask

  task automatic m_close();
    m_st = 3; m_done = 1;
    if (m_rem != 0) begin m_err = 1; m_found = 0; end
  endtask

  task automatic m_judge();
    bit take;
    take = m_mode ? (m_crev == m_cur) : (m_crev > m_rev);
    if (m_hit && take) begin m_rev = m_crev; m_idx = m_cidx; m_found = 1; end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_done = 0; m_found = 0; m_err = 0; m_idx = 0; m_rev = 0;
    end else if (scan_start) begin
      m_st = 1; m_rem = scan_len; m_cur = cur_rev; m_rev = cur_rev; m_mode = exact_mode;
      m_sig = cpu_sig; m_pf = pf_known ? (8'h01 << plat_field) : 8'h00;
      m_done = 0; m_found = 0; m_err = 0; m_idx = 0; m_hc = 0;
    end else if (m_st == 1) begin
      bit closing;
      logic [31:0] tot, dat;
      bit has_tab;
      closing = scan_end;
      if (hdr_valid) begin
        tot = (hdr_data_size == 0) ? 32'd2048 : hdr_total_size;
        dat = (hdr_data_size == 0) ? 32'd2000 : hdr_data_size;
        has_tab = tot > dat + 32'd48;
        if (!hdr_ok || tot == 0 || tot > m_rem || (has_tab && hdr_ext_count > 8'd15)) begin
          m_fail(); closing = 0;
        end else begin
          m_rem = m_rem - tot; m_cidx = m_hc; m_hc = m_hc + 8'd1; m_crev = hdr_rev;
          m_hit = m_match(hdr_sig, hdr_pf);
          if (has_tab && hdr_ext_count != 0) begin
            m_st = 2; m_left = int'(hdr_ext_count); closing = 0;
            if (scan_end) m_fail();
          end else m_judge();
        end
      end
      if (closing) m_close();
    end else if (m_st == 2) begin
      if (ext_valid) begin
        m_hit = m_hit | m_match(ext_sig, ext_pf);
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_st = 1; m_judge();
          if (scan_end) m_close();
        end else if (scan_end) m_fail();
      end else if (scan_end) m_fail();
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (done !== m_done || found !== m_found || err !== m_err ||
          sel_idx !== m_idx || sel_rev !== m_rev) begin
        errors++;
        $display("FAIL %s model: got d%0b f%0b e%0b i%0d r%0d exp d%0b f%0b e%0b i%0d r%0d",
                 tag, done, found, err, sel_idx, sel_rev, m_done, m_found, m_err, m_idx, m_rev);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic t_start(input logic [31:0] len, input logic [31:0] cur, input bit mode,
                         input bit pfk, input logic [2:0] fld);
    scan_start = 1; scan_len = len; cur_rev = cur; exact_mode = mode;
    pf_known = pfk; plat_field = fld;
    @(negedge clk);
    scan_start = 0;
  endtask

  task automatic t_hdr(input bit ok, input logic [31:0] sig, input logic [7:0] pf,
                       input logic [31:0] rev, input logic [31:0] dsz, input logic [31:0] tsz,
                       input logic [7:0] cnt, input bit e);
    hdr_valid = 1; hdr_ok = ok; hdr_sig = sig; hdr_pf = pf; hdr_rev = rev;
    hdr_data_size = dsz; hdr_total_size = tsz; hdr_ext_count = cnt; scan_end = e;
    @(negedge clk);
    hdr_valid = 0; scan_end = 0;
  endtask

  task automatic t_ext(input logic [31:0] sig, input logic [7:0] pf, input bit e);
    ext_valid = 1; ext_sig = sig; ext_pf = pf; scan_end = e;
    @(negedge clk);
    ext_valid = 0; scan_end = 0;
  endtask

  task automatic t_end();
    scan_end = 1;
    @(negedge clk);
    scan_end = 0;
  endtask

  task automatic expect_out(input string req, input bit d, input bit f, input bit e,
                            input logic [7:0] ix, input logic [31:0] rv);
    checks++;
    if (done !== d || found !== f || err !== e || sel_idx !== ix || sel_rev !== rv) begin
      errors++;
      $display("FAIL %s: got d%0b f%0b e%0b i%0d r%0d exp d%0b f%0b e%0b i%0d r%0d",
               req, done, found, err, sel_idx, sel_rev, d, f, e, ix, rv);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R11 reset", 0, 0, 0, 0, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R4 R10: newer mode, ties keep the earlier patch
    tag = "R4";
    t_start(4 * PLEN, 32'd4, 0, 0, 3'd0);
    t_hdr(1, SIG, 8'h00, 32'd5, 32'd1000, PLEN, 8'd0, 0);
    t_hdr(1, SIG, 8'h00, 32'd9, 32'd1000, PLEN, 8'd0, 0);
    t_hdr(1, SIG, 8'h00, 32'd7, 32'd1000, PLEN, 8'd0, 0);
    t_hdr(1, SIG, 8'h00, 32'd9, 32'd1000, PLEN, 8'd0, 1);
    expect_out("R4 R10 newest", 1, 1, 0, 8'd1, 32'd9);

    // R4: nothing newer than current
    t_start(2 * PLEN, 32'd20, 0, 0, 3'd0);
    t_hdr(1, SIG, 8'h00, 32'd5, 32'd1000, PLEN, 8'd0, 0);
    t_hdr(1, SIG, 8'h00, 32'd20, 32'd1000, PLEN, 8'd0, 1);
    expect_out("R4 none newer", 1, 0, 0, 8'd0, 32'd20);

    // R2: both masks zero match
    tag = "R2";
    t_start(PLEN, 32'd1, 0, 0, 3'd0);
    t_hdr(1, SIG, 8'h00, 32'd6, 32'd1000, PLEN, 8'd0, 1);
    expect_out("R2 zero masks", 1, 1, 0, 8'd0, 32'd6);

    // R1 R2: field 3 gives mask 0x08
    tag = "R1";
    t_start(3 * PLEN, 32'd1, 0, 1, 3'd3);
    t_hdr(1, SIG, 8'h03, 32'd8, 32'd1000, PLEN, 8'd0, 0);
    t_hdr(1, SIG, 8'h0C, 32'd7, 32'd1000, PLEN, 8'd0, 0);
    t_hdr(1, BAD, 8'hFF, 32'd9, 32'd1000, PLEN, 8'd0, 1);
    expect_out("R1 R2 mask intersect", 1, 1, 0, 8'd1, 32'd7);

    // R2: processor mask set, header mask zero -> no match
    t_start(PLEN, 32'd1, 0, 1, 3'd5);
    t_hdr(1, SIG, 8'h00, 32'd4, 32'd1000, PLEN, 8'd0, 1);
    expect_out("R2 one mask zero", 1, 0, 0, 8'd0, 32'd1);

    // R3 R9: extended entries, end with the last extended beat
    tag = "R3";
    t_start(32'd1104 + PLEN + 32'd1080, 32'd1, 0, 1, 3'd3);
    t_hdr(1, BAD, 8'h08, 32'd5, 32'd1000, 32'd1104, 8'd3, 0);
    t_ext(BAD, 8'h08, 0);
    t_ext(SIG, 8'h08, 0);
    t_ext(BAD, 8'h01, 0);
    expect_out("R3 ext hit", 0, 1, 0, 8'd0, 32'd5);
    t_hdr(1, SIG, 8'h08, 32'd3, 32'd1000, PLEN, 8'd5, 0);
    expect_out("R3 count ignored without table", 0, 1, 0, 8'd0, 32'd5);
    tag = "R9";
    t_hdr(1, BAD, 8'h08, 32'd7, 32'd1000, 32'd1080, 8'd1, 0);
    t_ext(SIG, 8'h18, 1);
    expect_out("R9 end with last ext beat", 1, 1, 0, 8'd2, 32'd7);

    // R5: exact mode, last equal patch wins
    tag = "R5";
    t_start(4 * PLEN, 32'd4, 1, 0, 3'd0);
    t_hdr(1, SIG, 8'h00, 32'd4, 32'd1000, PLEN, 8'd0, 0);
    t_hdr(1, SIG, 8'h00, 32'd4, 32'd1000, PLEN, 8'd0, 0);
    t_hdr(1, SIG, 8'h00, 32'd6, 32'd1000, PLEN, 8'd0, 0);
    t_hdr(1, SIG, 8'h01, 32'd4, 32'd1000, PLEN, 8'd0, 1);
    expect_out("R5 exact last", 1, 1, 0, 8'd1, 32'd4);

    // R6: invalid header
    tag = "R6";
    t_start(3 * PLEN, 32'd1, 0, 0, 3'd0);
    t_hdr(1, SIG, 8'h00, 32'd3, 32'd1000, PLEN, 8'd0, 0);
    t_hdr(0, SIG, 8'h00, 32'd4, 32'd1000, PLEN, 8'd0, 0);
    expect_out("R6 invalid abort", 1, 0, 1, 8'd0, 32'd3);
    // R6: patch larger than remaining
    t_start(32'd1000, 32'd1, 0, 0, 3'd0);
    t_hdr(1, SIG, 8'h00, 32'd3, 32'd900, PLEN, 8'd0, 0);
    expect_out("R6 oversize", 1, 0, 1, 8'd0, 32'd1);
    // R6: zero total
    t_start(32'd5000, 32'd1, 0, 0, 3'd0);
    t_hdr(1, SIG, 8'h00, 32'd3, 32'd1000, 32'd0, 8'd0, 0);
    expect_out("R6 zero size", 1, 0, 1, 8'd0, 32'd1);

    // R8: count above limit, then exactly at limit
    tag = "R8";
    t_start(32'd1260, 32'd1, 0, 0, 3'd0);
    t_hdr(1, SIG, 8'h00, 32'd3, 32'd1000, 32'd1260, 8'd16, 0);
    expect_out("R8 count over", 1, 0, 1, 8'd0, 32'd1);
    t_start(32'd1248, 32'd1, 0, 0, 3'd0);
    t_hdr(1, SIG, 8'h00, 32'd2, 32'd1000, 32'd1248, 8'd15, 0);
    for (int k = 0; k < 15; k++) t_ext(BAD, 8'h00, k == 14);
    expect_out("R8 count at limit", 1, 1, 0, 8'd0, 32'd2);

    // R7: default size when data size is zero
    tag = "R7";
    t_start(32'd2048, 32'd1, 0, 0, 3'd0);
    t_hdr(1, SIG, 8'h00, 32'd3, 32'd0, 32'd0, 8'd0, 1);
    expect_out("R7 default total", 1, 1, 0, 8'd0, 32'd3);
    t_start(32'd2048, 32'd1, 0, 0, 3'd0);
    t_hdr(1, SIG, 8'h00, 32'd4, 32'd0, 32'd9999, 8'd4, 1);
    expect_out("R7 total field ignored", 1, 1, 0, 8'd0, 32'd4);

    // R9: bytes left over, and end before the table is complete
    tag = "R9";
    t_start(32'd2000, 32'd1, 0, 0, 3'd0);
    t_hdr(1, SIG, 8'h00, 32'd3, 32'd1000, PLEN, 8'd0, 1);
    expect_out("R9 leftover", 1, 0, 1, 8'd0, 32'd3);
    t_start(32'd1104, 32'd1, 0, 0, 3'd0);
    t_hdr(1, SIG, 8'h00, 32'd3, 32'd1000, 32'd1104, 8'd3, 0);
    t_ext(BAD, 8'h00, 0);
    t_end();
    expect_out("R9 early end", 1, 0, 1, 8'd0, 32'd1);

    // R11: restart mid-scan, then hold after done
    tag = "R11";
    t_start(2 * PLEN, 32'd1, 0, 0, 3'd0);
    t_hdr(1, SIG, 8'h00, 32'd9, 32'd1000, PLEN, 8'd0, 0);
    t_start(PLEN, 32'd1, 0, 0, 3'd0);
    t_hdr(1, SIG, 8'h00, 32'd2, 32'd1000, PLEN, 8'd0, 1);
    expect_out("R11 restart", 1, 1, 0, 8'd0, 32'd2);
    t_hdr(1, SIG, 8'h00, 32'd50, 32'd1000, PLEN, 8'd0, 1);
    repeat (4) @(negedge clk);
    expect_out("R11 hold after done", 1, 1, 0, 8'd0, 32'd2);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got running exp finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule